// File: doc/BRIEF.md
# Lane-Wise Rounding Variable Shifter

This block shifts every lane of a 128-bit vector by its own signed amount. The data operand and a second control operand are both cut into lanes of equal width. For each lane, the low byte of the matching control lane is read as a signed shift count. A zero or positive count shifts the unsigned data element left. A negative count shifts it right by the count's magnitude, and the result is rounded to nearest with ties going up. Every lane result is cut back to the lane width.

The lane width is chosen by a two-bit size code. A full-width flag selects whether 64 or 128 bits of the vector are active. A scalar flag asks for exactly one 64-bit lane instead. Some combinations of these inputs are reserved. For those, the block raises an undefined flag and returns a zero result. All results are registered and come out one cycle after the input strobe. The surrounding datapath delivers the operands and decides what to do with the undefined flag.

Top module: `vec_round_shift`

## Requirements
- R1: The lane width in bits is 8 shifted left by `size_code`: code 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64. Lane k occupies bits [k*width +: width] of `data_in`, `ctrl_in` and `result`.
- R2: With `full_width` = 0 or `scalar_mode` = 1, only bits 63:0 are active and `result[127:64]` is zero. With `full_width` = 1 in vector mode, all 128 bits are active.
- R3: A request is undefined when it is in vector mode with `size_code` 3 and `full_width` 0, or in scalar mode with any `size_code` other than 3. An undefined request makes `out_undef` 1 and `result` all zero. `out_undef` is 0 in any cycle where `out_valid` is 0.
- R4: A lane's shift count is bits 7:0 of its control lane, read as a signed two's-complement number. Control bits above bit 7 have no effect on the result.
- R5: A count c with 0 <= c < width gives the data element shifted left by c bits, truncated to the lane width.
- R6: A count c >= width gives 0 in that lane.
- R7: A count -n with 1 <= n <= width gives floor((element + 2^(n-1)) / 2^n), truncated to the lane width. At n = width this equals the element's top bit.
- R8: A count -n with n > width, down to -128, gives 0 in that lane.
- R9: `out_valid` equals the previous cycle's `in_valid`. `result` and `out_undef` belong to the request accepted at that edge. `result` keeps its value in cycles with no request. A synchronous reset clears `out_valid`, `out_undef` and `result`.
- R10: In scalar mode with `size_code` 3, a single 64-bit lane is taken from bits 63:0 and its result is placed in bits 63:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| size_code | input | 2 | Lane width code |
| full_width | input | 1 | 1 selects 128 active bits, 0 selects 64 |
| scalar_mode | input | 1 | Single 64-bit lane request |
| data_in | input | 128 | Unsigned data lanes |
| ctrl_in | input | 128 | Control lanes; the low byte of each lane is the signed count |
| out_valid | output | 1 | Registered strobe, one cycle after `in_valid` |
| out_undef | output | 1 | Registered undefined-encoding flag |
| result | output | 128 | Registered shifted lanes |

## Verification
Each request gives its `out_valid`, `out_undef` and `result` on the rising edge that follows the edge where it was presented, so all three are due exactly one cycle later. The bench drives a new request on each falling edge. On the next falling edge it compares every output against the value its behavioural model computed for the previous request, half a period after the capturing edge. Idle cycles are compared the same way: `out_valid` and `out_undef` must be low. The model evaluates every lane on its own from the requirements. The control lanes carry counts drawn from a list that includes -128, -width-1, -width, -1, 0, width-1, width and 127, with random bits above the count byte.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

  localparam int SZ_W   = 2;
  localparam int NUM_SZ = 1 << SZ_W;

  typedef enum logic [SZ_W-1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } lane_sz_e;

  // Reserved encodings: vector with widest lanes at half width,
  // or scalar with anything but the widest lane.
  function automatic logic vrs_undef(input logic [SZ_W-1:0] sz,
                                     input logic full,
                                     input logic scal);
    if (scal) return (sz != SZ_DWORD);
    return (sz == SZ_DWORD) && !full;
  endfunction

endpackage

// File: rtl/rs_lane_shifter.sv
module rs_lane_shifter #(
  parameter int LANE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic [LANE_W-1:0] elem_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [LANE_W-1:0] res_o
);

  localparam logic [CNT_W:0] LANE_W_C = (CNT_W+1)'(LANE_W);
  localparam logic [CNT_W:0] ONE_C    = (CNT_W+1)'(1);

  logic            neg;
  logic [CNT_W:0]  mag;
  logic [LANE_W:0] ext;
  logic [LANE_W:0] rnd;
  logic [LANE_W:0] sum;
  logic [LANE_W:0] shr;
  logic            unused_shr_top;

  assign neg = cnt_i[CNT_W-1];
  // magnitude of the signed count, one bit wider so -128 fits
  assign mag = neg ? (~{1'b1, cnt_i} + ONE_C) : {1'b0, cnt_i};

  // one guard bit above the lane keeps the rounding carry
  assign ext = {1'b0, elem_i};
  assign rnd = (LANE_W+1)'(1) << (mag - ONE_C);
  assign sum = ext + rnd;
  assign shr = sum >> mag;
  assign unused_shr_top = shr[LANE_W];

  always_comb begin
    if (!neg) begin
      res_o = (mag < LANE_W_C) ? (elem_i << mag) : '0;
    end else if (mag > LANE_W_C) begin
      res_o = '0;
    end else begin
      res_o = shr[LANE_W-1:0];
    end
  end

  // R7: a right shift by the full lane width rounds to the element's top bit
  always_comb begin
    if (!$isunknown(elem_i) && !$isunknown(cnt_i) && neg && (mag == LANE_W_C)) begin
      a_r7_full_width_round: assert (res_o == LANE_W'(elem_i[LANE_W-1]));
    end
  end

endmodule

// File: rtl/rs_lane_array.sv
module rs_lane_array #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic [VEC_W-1:0] data_i,
  input  logic [VEC_W-1:0] ctrl_i,
  output logic [VEC_W-1:0] res_o
);

  localparam int LANES = VEC_W / LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rs_lane_shifter #(
      .LANE_W(LANE_W),
      .CNT_W (CNT_W)
    ) u_sh (
      .elem_i(data_i[i*LANE_W +: LANE_W]),
      .cnt_i (ctrl_i[i*LANE_W +: CNT_W]),
      .res_o (res_o[i*LANE_W +: LANE_W])
    );

    // R4: control bits above the count byte play no part
    if (LANE_W > CNT_W) begin : g_hi
      logic unused_ctrl_hi;
      assign unused_ctrl_hi = ^ctrl_i[i*LANE_W+CNT_W +: LANE_W-CNT_W];
    end
  end

endmodule

// File: rtl/vec_round_shift.sv
module vec_round_shift
  import vrs_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int LANE_MIN = 8,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SZ_W-1:0]  size_code,
  input  logic             full_width,
  input  logic             scalar_mode,
  input  logic [VEC_W-1:0] data_in,
  input  logic [VEC_W-1:0] ctrl_in,
  output logic             out_valid,
  output logic             out_undef,
  output logic [VEC_W-1:0] result
);

  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] res_by_sz [NUM_SZ];
  logic [VEC_W-1:0] lane_pick;
  logic [VEC_W-1:0] res_nxt;
  logic             bad;
  logic             half;

  // one lane array per lane width; the size code picks among them
  for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
    rs_lane_array #(
      .VEC_W (VEC_W),
      .LANE_W(LANE_MIN << g),
      .CNT_W (CNT_W)
    ) u_arr (
      .data_i(data_in),
      .ctrl_i(ctrl_in),
      .res_o (res_by_sz[g])
    );
  end

  always_comb begin
    bad       = vrs_undef(size_code, full_width, scalar_mode);
    half      = scalar_mode | ~full_width;
    lane_pick = scalar_mode ? res_by_sz[NUM_SZ-1] : res_by_sz[size_code];
    res_nxt   = lane_pick;
    if (half) res_nxt[VEC_W-1:HALF_W] = '0;
    if (bad)  res_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      out_undef <= in_valid & bad;
      if (in_valid) result <= res_nxt;
    end
  end

  // R9: the strobe is delayed by exactly one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R3: the undefined flag only travels with a valid result, which is then zero
  a_r3_undef_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> out_valid);
  a_r3_undef_zero: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> (result == '0));
  // R2: a half-width or scalar request leaves the upper half at zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (!full_width || scalar_mode)) |=> (result[VEC_W-1:HALF_W] == '0));
  // R9: without a request the result holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_valid) |=> $stable(result));

endmodule

// File: tb/vec_round_shift_tb_top.sv
`timescale 1ns/1ps
module vec_round_shift_tb_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   size_code;
  logic         full_width;
  logic         scalar_mode;
  logic [127:0] data_in;
  logic [127:0] ctrl_in;
  logic         out_valid;
  logic         out_undef;
  logic [127:0] result;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  // expectation for the request presented on the previous falling edge
  logic         exp_valid;
  logic         exp_undef;
  logic [127:0] exp_res;
  logic         exp_half;
  int           exp_w;
  int           exp_lanes;
  int           exp_cnt [16];

  always #4 clk = ~clk;

  vec_round_shift dut_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .size_code  (size_code),
    .full_width (full_width),
    .scalar_mode(scalar_mode),
    .data_in    (data_in),
    .ctrl_in    (ctrl_in),
    .out_valid  (out_valid),
    .out_undef  (out_undef),
    .result     (result)
  );

  function automatic logic [63:0] ref_lane(logic [63:0] e, logic [7:0] cb, int w);
    int          c;
    int          n;
    logic [64:0] x;
    logic [63:0] m;
    c = int'($signed(cb));
    m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    if (c >= 0) begin
      if (c >= w) return 64'd0;
      x = {1'b0, e} << c;
      return x[63:0] & m;
    end
    n = -c;
    if (n > w) return 64'd0;
    x = ({1'b0, e} + (65'd1 << (n - 1))) >> n;
    return x[63:0] & m;
  endfunction

  function automatic string req_of(int c, int w);
    if (c >= w)       return "R6";
    if (c >= 0)       return "R5";
    if (-c <= w)      return "R7";
    return "R8";
  endfunction

  function automatic logic [7:0] pick_cnt(int w, int k);
    case (k)
      0:  return 8'h80;
      1:  return 8'(-w);
      2:  return 8'(-w - 1);
      3:  return 8'(-w + 1);
      4:  return 8'hFF;
      5:  return 8'h00;
      6:  return 8'h01;
      7:  return 8'(w - 1);
      8:  return 8'(w);
      9:  return 8'(w + 1);
      10: return 8'h7F;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    logic [63:0] a;
    logic [63:0] e;
    check(out_valid == exp_valid, "R9", "out_valid", 128'(out_valid), 128'(exp_valid));
    if (!exp_valid) begin
      check(out_undef == 1'b0, "R3", "undef while idle", 128'(out_undef), 128'd0);
      return;
    end
    check(out_undef == exp_undef, "R3", "out_undef", 128'(out_undef), 128'(exp_undef));
    if (exp_undef) begin
      check(result == '0, "R3", "undefined result", result, 128'd0);
      return;
    end
    // R1 lane layout, R10 scalar lane: each lane judged by its own count
    for (int l = 0; l < exp_lanes; l++) begin
      a = 64'(result  >> (l * exp_w));
      e = 64'(exp_res >> (l * exp_w));
      if (exp_w < 64) begin
        a &= (64'd1 << exp_w) - 64'd1;
        e &= (64'd1 << exp_w) - 64'd1;
      end
      check(a == e, req_of(exp_cnt[l], exp_w), $sformatf("lane %0d w%0d cnt %0d", l, exp_w, exp_cnt[l]),
            128'(a), 128'(e));
    end
    if (exp_half)
      check(result[127:64] == 64'd0, "R2", "upper half", 128'(result[127:64]), 128'd0);
  endtask

  task automatic step(bit v, bit scal, bit full, logic [1:0] sz, logic [127:0] d, logic [127:0] c);
    int          w;
    int          act_w;
    logic [63:0] el;
    logic [7:0]  cb;
    @(negedge clk);
    compare_outputs();
    in_valid    = v;
    scalar_mode = scal;
    full_width  = full;
    size_code   = sz;
    data_in     = d;
    ctrl_in     = c;
    w           = scal ? 64 : (8 << sz);
    act_w       = (scal || !full) ? 64 : 128;
    exp_valid   = v;
    exp_undef   = v && (scal ? (sz != 2'd3) : (sz == 2'd3 && !full));
    exp_half    = (act_w == 64);
    exp_w       = w;
    exp_lanes   = act_w / w;
    exp_res     = '0;
    for (int l = 0; l < exp_lanes; l++) begin
      el = 64'(d >> (l * w));
      cb = 8'(c >> (l * w));
      if (w < 64) el &= (64'd1 << w) - 64'd1;
      exp_cnt[l] = int'($signed(cb));
      exp_res |= 128'(ref_lane(el, cb, w)) << (l * w);
    end
  endtask

  function automatic logic [127:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [127:0] d;
    logic [127:0] c;
    logic [63:0]  lane;
    int           w;
    rst = 1'b1; in_valid = 1'b0; size_code = '0; full_width = 1'b0;
    scalar_mode = 1'b0; data_in = '0; ctrl_in = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9", "reset out_valid", 128'(out_valid), 128'd0);
    check(out_undef == 1'b0, "R9", "reset out_undef", 128'(out_undef), 128'd0);
    check(result == '0, "R9", "reset result", result, 128'd0);
    rst = 1'b0;
    exp_valid = 1'b0;
    exp_undef = 1'b0;

    // R10: scalar top bit set, shifted right by the full 64 rounds to 1
    step(1, 1, 0, 2'd3, {64'hFFFF_0000_FFFF_0000, 64'h8000_0000_0000_0000}, {120'd0, 8'hC0});
    // R4: identical counts with different upper control bits
    step(1, 0, 1, 2'd1, {8{16'h00F3}}, {8{16'hAB02}});
    step(1, 0, 1, 2'd1, {8{16'h00F3}}, {8{16'h5502}});

    for (int s = 0; s < 2; s++) begin
      for (int f = 0; f < 2; f++) begin
        for (int z = 0; z < 4; z++) begin
          for (int r = 0; r < 120; r++) begin
            w = (s != 0) ? 64 : (8 << z);
            d = rand128();
            if (r % 5 == 0) d = ~128'd0;
            c = '0;
            for (int l = 0; l < 128 / w; l++) begin
              lane = {$urandom, $urandom};
              lane[7:0] = pick_cnt(w, (r + l) % 12);
              if (w < 64) lane &= (64'd1 << w) - 64'd1;
              c |= 128'(lane) << (l * w);
            end
            step((r % 7) != 6, s[0], f[0], z[1:0], d, c);
          end
        end
      end
    end
    step(0, 0, 0, 2'd0, '0, '0);
    step(0, 0, 0, 2'd0, '0, '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule